// File: doc/BRIEF.md
# Asynchronous Serial Port with Fractional Bit-Rate Divider

This block is a full-duplex asynchronous serial port. A transmitter turns a byte written to its data register into a frame on `txd`. A receiver watches `rxd`, rebuilds frames and holds the last one for the host. Both sides share one oversampling tick, which comes at sixteen times the bit rate. An integer divider and a fractional accumulator produce that tick. Because of the fraction, the bit period is exact when averaged over a bit rather than rounded to whole clocks.

The frame has 5 to 9 data bits, an optional odd or even parity bit, and one or two stop bits. The receiver passes `rxd` through a synchronizer. It decides each bit by a vote over three samples around the bit centre. A falling edge starts a frame, and the receiver drops the frame if the line is high again at the start bit's centre. Each received frame carries a parity error flag and a framing error flag. Overrun is flagged when a frame lands on an unread one. The transmit side reports two things separately: that its data register is free, and that the line has gone quiet.

Top module: `async_serial_port`

## Requirements
- R1: One tick lasts `cfg_div_int`+1 clocks, plus one more clock when the 4-bit fraction accumulator carries. Every transmitted bit is 16 ticks, so it lasts exactly 16*(`cfg_div_int`+1)+`cfg_div_frac` clocks.
- R2: A frame is sent in this order: a low start bit, the data bits least significant first, the parity bit if enabled, then one stop bit (`cfg_two_stop`=0) or two (`cfg_two_stop`=1). A byte that waits in the data register starts right after the last stop bit of the previous frame, with no gap.
- R3: `cfg_data_bits` (5 to 9) sets the number of data bits. Only the low bits of `tx_data` are sent. `rx_data` holds the received bits right-aligned, with zeros above them.
- R4: With `cfg_par_en`=1, a parity bit follows the data. The data bits plus the parity bit hold an even number of ones when `cfg_par_odd`=0 and an odd number when it is 1. A received parity bit that breaks this rule sets `rx_perr` for that frame.
- R5: When the first stop bit is decided low, `rx_ferr` is set for that frame.
- R6: If a frame completes while `rx_ready` is still set and `rx_rd` is not asserted, `rx_ovr` is set and `rx_data` takes the new frame.
- R7: A low pulse on `rxd` that has ended before sample 8 of 16 of the start bit is discarded. No frame is reported.
- R8: Each bit value is the majority of samples 7, 8 and 9. A glitch that spans a single sample does not change the received data.
- R9: `tx_empty` is high while the data register is free. A `tx_wr` while `tx_empty` is low is ignored, and the byte it carries is never sent.
- R10: `tx_done` rises only after the last stop bit has left the line while the data register is empty. It stays low between back-to-back frames, and an accepted write clears it.
- R11: `rx_ready` rises when a frame completes. An `rx_rd` pulse clears both `rx_ready` and `rx_ovr`.
- R12: After reset, `txd` is high, `tx_empty` is high, and `tx_done`, `rx_ready` and `rx_ovr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div_int | input | INT_W | Integer tick divider (period minus one) |
| cfg_div_frac | input | FRAC_W | Fraction added to the accumulator once per tick |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_data | input | 9 | Byte to transmit |
| tx_empty | output | 1 | Transmit data register free |
| tx_done | output | 1 | Transmission complete, line idle |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read strobe for the received byte |
| rx_data | output | 9 | Last received data, right-aligned |
| rx_ready | output | 1 | Received byte waiting |
| rx_perr | output | 1 | Parity error on the held byte |
| rx_ferr | output | 1 | Framing error on the held byte |
| rx_ovr | output | 1 | Overrun: a held byte was overwritten |

## Verification
The transmitter and the receiver run on the same tick. In loopback, the receiver finishes frame N in the same stretch of cycles in which the transmitter takes frame N+1 out of its data register. A monitor reads each byte as soon as it appears. The scoreboard then has to see every queued byte, in order and with clean flags, while the driver keeps the data register full. To provoke overrun, a second frame is made to land on an unread first one; the flags and the held data are then judged at the ports. Corrupt parity, a low stop bit, single-sample glitches and a runt start pulse are driven by hand on `rxd` at an exact bit period.

// File: rtl/sap_pkg.sv
package sap_pkg;
   localparam int DATA_W  = 9;            // widest data field
   localparam int FRAME_W = DATA_W + 4;   // start + data + parity + two stops
   localparam int OVS     = 16;           // ticks per bit
   localparam int MID_A   = 7;
   localparam int MID_B   = 8;
   localparam int MID_C   = 9;

   typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

   // force the data-bit count into the legal 5..9 window
   function automatic logic [3:0] clamp_bits(input logic [3:0] v);
      if (v < 4'd5)      return 4'd5;
      else if (v > 4'd9) return 4'd9;
      else               return v;
   endfunction
endpackage

// File: rtl/sap_baud_gen.sv
module sap_baud_gen #(
   parameter int INT_W  = 12,
   parameter int FRAC_W = 4,
   localparam int FP_W  = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] div_int,
   input  logic [FP_W-1:0]  div_frac,
   output logic             tick
);
   if (INT_W < 1) begin : g_bad_int
      $error("sap_baud_gen: INT_W must be at least 1");
   end

   logic [INT_W:0] cnt;
   logic           carry;

   assign tick = (cnt == '0);

   if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W-1:0] acc;
      logic [FRAC_W:0]   sum;
      assign sum   = {1'b0, acc} + {1'b0, div_frac};
      assign carry = sum[FRAC_W];
      always_ff @(posedge clk) begin
         if (!rst_n)    acc <= '0;
         else if (tick) acc <= sum[FRAC_W-1:0];
      end
   end else begin : g_int_only
      assign carry = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= {1'b0, div_int} + {{INT_W{1'b0}}, carry};
      else           cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/sap_tx.sv
module sap_tx
   import sap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [3:0]        nbits,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              txd,
   output logic              empty,
   output logic              done
);
   logic [DATA_W-1:0]  hold;
   logic               full;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame;
   logic [3:0]         left;
   logic [3:0]         sub;
   logic [3:0]         flen;
   logic               busy;
   logic               par_bit;
   logic               last_tick;
   logic               load;

   // assemble the frame from the held word: LSB on the line first
   always_comb begin
      par_bit = par_odd;
      frame   = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(nbits)) begin
            frame[i+1] = hold[i];
            par_bit    = par_bit ^ hold[i];
         end
      end
      if (par_en) frame[int'(nbits)+1] = par_bit;
      flen = 4'd2 + nbits + {3'b0, par_en} + {3'b0, two_stop};
   end

   assign last_tick = tick && busy && (sub == 4'(OVS-1)) && (left == 4'd1);
   assign load      = tick && full && (!busy || last_tick);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold  <= '0;
         full  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         sub   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         if (wr && !full) begin
            hold <= wdata;
            full <= 1'b1;
            done <= 1'b0;
         end
         if (tick && busy) begin
            sub <= sub + 1'b1;
            if (sub == 4'(OVS-1)) begin
               if (left == 4'd1) begin
                  busy <= 1'b0;
                  if (!full && !wr) done <= 1'b1;
               end else begin
                  shreg <= {1'b1, shreg[FRAME_W-1:1]};
                  left  <= left - 1'b1;
               end
            end
         end
         if (load) begin
            shreg <= frame;
            left  <= flen;
            sub   <= '0;
            busy  <= 1'b1;
            full  <= 1'b0;
         end
      end
   end

   assign txd   = busy ? shreg[0] : 1'b1;
   assign empty = !full;
endmodule

// File: rtl/sap_rx.sv
module sap_rx
   import sap_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [3:0]        nbits,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rxd,
   input  logic              rd,
   output logic [DATA_W-1:0] data,
   output logic              ready,
   output logic              perr,
   output logic              ferr,
   output logic              ovr
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sap_rx: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync;
   logic                   s;

   always_ff @(posedge clk) begin
      if (!rst_n) sync <= '1;
      else        sync <= {sync[SYNC_STAGES-2:0], rxd};
   end
   assign s = sync[SYNC_STAGES-1];

   rx_state_t         st;
   logic              prev;
   logic [3:0]        samp;
   logic [3:0]        nxt;
   logic [3:0]        pos;
   logic [3:0]        k;
   logic              v7;
   logic              v8;
   logic              maj;
   logic              parbit;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] word;

   assign nxt  = samp + 1'b1;
   assign k    = pos - 1'b1;
   assign maj  = (v7 & v8) | (v7 & s) | (v8 & s);
   assign word = sh >> (4'(DATA_W) - nbits);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         prev   <= 1'b1;
         samp   <= '0;
         pos    <= '0;
         v7     <= 1'b1;
         v8     <= 1'b1;
         parbit <= 1'b0;
         sh     <= '0;
         data   <= '0;
         ready  <= 1'b0;
         perr   <= 1'b0;
         ferr   <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         if (rd) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
         end
         if (tick) begin
            if (st == RX_IDLE) begin
               prev <= s;
               if (prev && !s) begin
                  st   <= RX_BUSY;
                  samp <= '0;
                  pos  <= '0;
               end
            end else begin
               samp <= nxt;
               if (nxt == 4'd0) pos <= pos + 1'b1;
               if (nxt == 4'(MID_A)) v7 <= s;
               if (nxt == 4'(MID_B)) begin
                  v8 <= s;
                  if (pos == 4'd0 && s) begin
                     st   <= RX_IDLE;
                     prev <= 1'b1;
                  end
               end
               if (nxt == 4'(MID_C) && pos != 4'd0) begin
                  if (k < nbits) begin
                     sh <= {maj, sh[DATA_W-1:1]};
                  end else if (par_en && k == nbits) begin
                     parbit <= maj;
                  end else begin
                     st    <= RX_IDLE;
                     prev  <= maj;
                     data  <= word;
                     perr  <= par_en & (parbit ^ (^word) ^ par_odd);
                     ferr  <= !maj;
                     ovr   <= ready && !rd;
                     ready <= 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
   import sap_pkg::*;
#(
   parameter int INT_W       = 12,
   parameter int FRAC_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int FP_W       = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  cfg_div_int,
   input  logic [FP_W-1:0]   cfg_div_frac,
   input  logic [3:0]        cfg_data_bits,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_empty,
   output logic              tx_done,
   output logic              txd,
   input  logic              rxd,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              rx_perr,
   output logic              rx_ferr,
   output logic              rx_ovr
);
   if (FRAC_W > 8) begin : g_bad_frac
      $error("async_serial_port: FRAC_W above 8 is not supported");
   end

   logic       tick;
   logic [3:0] nbits;

   assign nbits = clamp_bits(cfg_data_bits);

   sap_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_int  (cfg_div_int),
      .div_frac (cfg_div_frac),
      .tick     (tick)
   );

   sap_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .nbits    (nbits),
      .par_en   (cfg_par_en),
      .par_odd  (cfg_par_odd),
      .two_stop (cfg_two_stop),
      .wr       (tx_wr),
      .wdata    (tx_data),
      .txd      (txd),
      .empty    (tx_empty),
      .done     (tx_done)
   );

   sap_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .nbits   (nbits),
      .par_en  (cfg_par_en),
      .par_odd (cfg_par_odd),
      .rxd     (rxd),
      .rd      (rx_rd),
      .data    (rx_data),
      .ready   (rx_ready),
      .perr    (rx_perr),
      .ferr    (rx_ferr),
      .ovr     (rx_ovr)
   );
endmodule

// File: rtl/async_serial_port_chk.sv
module async_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_wr,
   input logic tx_empty,
   input logic tx_done,
   input logic txd,
   input logic rx_rd,
   input logic rx_ready,
   input logic rx_ovr
);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (tx_empty && txd));

   assert_done_cleared_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_done) |-> $past(tx_wr));

   assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_empty) |=> !tx_empty);

   assert_empty_fall_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(tx_wr));

   assert_overrun_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |-> rx_ready);

   assert_read_clears_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_ready) |=> !rx_ovr);
endmodule

bind async_serial_port async_serial_port_chk u_chk (.*);

// File: tb/async_serial_port_test.sv
module async_serial_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [11:0] cfg_div_int = 12'd1;
   logic [3:0] cfg_div_frac = 4'd0;
   logic [3:0] cfg_data_bits = 4'd8;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       tx_wr = 1'b0;
   logic [8:0] tx_data = '0;
   logic       tx_empty, tx_done, txd;
   logic       rxd;
   logic       rx_rd = 1'b0;
   logic [8:0] rx_data;
   logic       rx_ready, rx_perr, rx_ferr, rx_ovr;

   logic       loop = 1'b1;
   logic       rxd_man = 1'b1;
   logic       mon_en = 1'b1;
   int         nchk = 0;
   int         nfail = 0;
   int         nrecv = 0;

   typedef struct {logic [8:0] d; logic pe; logic fe;} exp_t;
   exp_t sbq[$];

   assign rxd = loop ? txd : rxd_man;

   always #5 clk = ~clk;

   async_serial_port uut (
      .clk(clk), .rst_n(rst_n), .cfg_div_int(cfg_div_int), .cfg_div_frac(cfg_div_frac),
      .cfg_data_bits(cfg_data_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
      .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
      .rx_ready(rx_ready), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   // driver: write one word, optionally queue what the receiver must deliver
   task automatic send(input logic [8:0] d, input logic [8:0] expect_d, input bit push);
      while (!tx_empty) @(negedge clk);
      tx_data = d;
      tx_wr   = 1'b1;
      @(negedge clk);
      tx_wr   = 1'b0;
      if (push) sbq.push_back('{expect_d, 1'b0, 1'b0});
   endtask

   task automatic wait_done();
      while (!tx_done) @(negedge clk);
      repeat (200) @(negedge clk);
   endtask

   // drive one 8-bit even-parity frame on rxd by hand, 32 clocks per bit
   task automatic drive_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit glitch);
      logic [10:0] bits;
      bits = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
      for (int b = 0; b < 11; b++) begin
         for (int c = 0; c < 32; c++) begin
            if (glitch && b >= 1 && b <= 8 && (c == 18 || c == 19)) rxd_man = ~bits[b];
            else rxd_man = bits[b];
            @(negedge clk);
         end
      end
      rxd_man = 1'b1;
      repeat (64) @(negedge clk);
   endtask

   // monitor: pop and compare each completed frame, then read it
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en && rx_ready) begin
            nrecv++;
            if (sbq.size() == 0) begin
               chk(1'b0, "R9/R11 unexpected frame", int'(rx_data), 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(rx_data == e.d, "R2/R3 received data", int'(rx_data), int'(e.d));
               chk(rx_perr == e.pe, "R4 parity flag", int'(rx_perr), int'(e.pe));
               chk(rx_ferr == e.fe, "R5 framing flag", int'(rx_ferr), int'(e.fe));
            end
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog R0 actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int len;
      int gap;
      int base;
      bit done_seen;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(txd == 1'b1, "R12 txd", int'(txd), 1);
      chk(tx_empty == 1'b1, "R12 tx_empty", int'(tx_empty), 1);
      chk(tx_done == 1'b0, "R12 tx_done", int'(tx_done), 0);
      chk(rx_ready == 1'b0, "R12 rx_ready", int'(rx_ready), 0);
      chk(rx_ovr == 1'b0, "R12 rx_ovr", int'(rx_ovr), 0);

      // R2 R3 basic 8N1 loopback
      send(9'h0A5, 9'h0A5, 1'b1);
      @(negedge clk);
      chk(tx_done == 1'b0, "R10 done low while sending", int'(tx_done), 0);
      send(9'h03C, 9'h03C, 1'b1);
      send(9'h1FF, 9'h0FF, 1'b1);
      wait_done();
      chk(tx_empty && txd, "R10 idle at done", int'({tx_empty, txd}), 3);
      chk(sbq.size() == 0, "R2 all frames seen", sbq.size(), 0);

      // R2 R9 R10 back-to-back 8N2: spacing 11 bits, third write ignored
      cfg_two_stop = 1'b1;
      base = nrecv;
      gap = 0;
      done_seen = 1'b0;
      fork
         begin
            while (txd) @(negedge clk);
            while (!txd) begin gap++; @(negedge clk); end
            while (txd) begin gap++; done_seen |= tx_done; @(negedge clk); end
         end
         begin
            send(9'h000, 9'h000, 1'b1);
            while (!tx_empty) @(negedge clk);
            tx_data = 9'h055; tx_wr = 1'b1; @(negedge clk);
            tx_data = 9'h0C3; @(negedge clk);   // register full: must be dropped
            tx_wr = 1'b0;
            sbq.push_back('{9'h055, 1'b0, 1'b0});
         end
      join
      chk(gap == 352, "R2 frame spacing 8N2", gap, 352);
      chk(!done_seen, "R10 done low between frames", int'(done_seen), 0);
      wait_done();
      repeat (600) @(negedge clk);
      chk(nrecv == base + 2, "R9 ignored write not sent", nrecv - base, 2);
      cfg_two_stop = 1'b0;

      // R1 fractional bit period
      cfg_div_int = 12'd2;
      cfg_div_frac = 4'd5;
      repeat (20) @(negedge clk);
      fork
         begin
            len = 0;
            while (txd) @(negedge clk);
            while (!txd) begin len++; @(negedge clk); end
         end
         send(9'h001, 9'h001, 1'b1);
      join
      chk(len == 53, "R1 bit length frac 5", len, 53);
      wait_done();
      cfg_div_frac = 4'd11;
      repeat (20) @(negedge clk);
      fork
         begin
            len = 0;
            while (txd) @(negedge clk);
            while (!txd) begin len++; @(negedge clk); end
         end
         send(9'h0F1, 9'h0F1, 1'b1);
      join
      chk(len == 59, "R1 bit length frac 11", len, 59);
      wait_done();

      // R3 R4 other widths and parities in loopback
      cfg_div_int = 12'd1;
      cfg_div_frac = 4'd0;
      cfg_data_bits = 4'd5;
      cfg_par_en = 1'b1;
      cfg_par_odd = 1'b0;
      repeat (20) @(negedge clk);
      send(9'h1F5, 9'h015, 1'b1);
      wait_done();
      cfg_data_bits = 4'd9;
      cfg_par_odd = 1'b1;
      cfg_two_stop = 1'b1;
      send(9'h1A3, 9'h1A3, 1'b1);
      send(9'h100, 9'h100, 1'b1);
      wait_done();
      chk(sbq.size() == 0, "R3 wide frames seen", sbq.size(), 0);

      // hand-driven receive: 8 bits even parity one stop
      loop = 1'b0;
      cfg_data_bits = 4'd8;
      cfg_par_odd = 1'b0;
      cfg_two_stop = 1'b0;
      repeat (64) @(negedge clk);
      sbq.push_back('{9'h0B4, 1'b1, 1'b0});
      drive_frame(8'hB4, 1'b1, 1'b0, 1'b0);      // R4 bad parity
      sbq.push_back('{9'h06D, 1'b0, 1'b1});
      drive_frame(8'h6D, 1'b0, 1'b1, 1'b0);      // R5 low stop
      sbq.push_back('{9'h0A6, 1'b0, 1'b0});
      drive_frame(8'hA6, 1'b0, 1'b0, 1'b1);      // R8 glitches at bit centres
      chk(sbq.size() == 0, "R8 hand frames seen", sbq.size(), 0);

      // R7 runt start pulse
      base = nrecv;
      rxd_man = 1'b0;
      repeat (8) @(negedge clk);
      rxd_man = 1'b1;
      repeat (600) @(negedge clk);
      chk(rx_ready == 1'b0 && nrecv == base, "R7 false start rejected", nrecv - base, 0);
      sbq.push_back('{9'h05A, 1'b0, 1'b0});
      drive_frame(8'h5A, 1'b0, 1'b0, 1'b0);
      chk(sbq.size() == 0, "R7 frame after runt", sbq.size(), 0);

      // R6 R11 overrun
      loop = 1'b1;
      cfg_par_en = 1'b0;
      mon_en = 1'b0;
      repeat (64) @(negedge clk);
      send(9'h011, 9'h0, 1'b0);
      send(9'h022, 9'h0, 1'b0);
      wait_done();
      chk(rx_ready == 1'b1, "R11 ready held", int'(rx_ready), 1);
      chk(rx_ovr == 1'b1, "R6 overrun flag", int'(rx_ovr), 1);
      chk(rx_data == 9'h022, "R6 newest data kept", int'(rx_data), 'h22);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      @(negedge clk);
      chk(rx_ready == 1'b0, "R11 read clears ready", int'(rx_ready), 0);
      chk(rx_ovr == 1'b0, "R11 read clears overrun", int'(rx_ovr), 0);

      finish_run();
   end
endmodule